// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column address for each beat of an SDRAM read or write burst. A start strobe presents a starting column together with a burst length code, an order bit and an organisation code. One clock later the first beat appears on the outputs. From then on one column address is emitted per clock until the burst completes or a terminate request ends it.

Fixed bursts of 2, 4 or 8 beats stay inside the aligned block of that size. The address either counts upward and wraps inside the block, or follows an XOR (interleaved) order. A full-page burst steps through every column of the row and wraps at the row end. It runs until it is terminated. The organisation code narrows the column to 10, 9 or 8 bits, so the same block serves every I/O width.

A start strobe may arrive on any clock, including in the middle of a running burst. The new burst then begins on the next cycle.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is low, and on the first cycle after it rises, `beat_vld_o`, `last_o` and `col_o` are all zero.
- R2: A start strobe sampled on a rising edge makes `beat_vld_o` high after that edge, with `col_o` equal to the starting column with its unused bits cleared (beat 0).
- R3: Length codes are: 0 for 1 beat, 1 for 2, 2 for 4, 3 for 8 and 7 for full page; codes 4 to 6 act as 1 beat. With order bit `interleave_i`=0 and a fixed length BL, beat n keeps the bits above the low log2(BL) bits and sets the low bits to (start + n) mod BL.
- R4: With `interleave_i`=1 and a fixed length BL, beat n sets the low log2(BL) bits to start XOR n and keeps the upper bits.
- R5: A fixed-length burst of BL beats that is not interrupted gives exactly BL valid beats. `last_o` is high on the final beat only, and `beat_vld_o` is low on the cycle after it.
- R6: A burst of length 1 (or a code from 4 to 6) gives a single valid beat that is also flagged last.
- R7: A full-page burst adds one to the column on each beat and wraps from the top column of the organisation to 0. It ignores the order bit, never raises `last_o`, and keeps running until terminated.
- R8: `stop_i` sampled high without a start while a burst is valid makes `beat_vld_o` low on the next cycle.
- R9: A start strobe takes priority over continuation and over `stop_i`: the new burst's beat 0 appears on the very next cycle.
- R10: Organisation code 0 uses 10 column bits, code 1 uses 9 bits, and codes 2 and 3 use 8 bits. The unused upper bits of `col_o` are always 0.
- R11: Length, order and organisation inputs are sampled only with a start strobe. Changing them during a burst does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a new burst on this edge |
| start_col_i | input | COL_W | Starting column address |
| bl_code_i | input | 3 | Burst length code |
| interleave_i | input | 1 | 0 = sequential wrap, 1 = interleaved order |
| org_i | input | 2 | Organisation code selecting the column width |
| stop_i | input | 1 | Terminate the running burst |
| col_o | output | COL_W | Column address of the current beat |
| beat_vld_o | output | 1 | Current beat is valid |
| last_o | output | 1 | Current beat is the last of a fixed-length burst |

## Verification
The bench builds the block with the default `COL_W` of 10. This makes all three organisation widths reachable: the 10-bit case, and the 9-bit and 8-bit narrowings where the top bits must read as zero, including a full-page wrap at each row end. Stimulus covers every length code, including a reserved one, in both orders. It also covers mid-burst restarts, a start coinciding with a terminate, and a mode change made during a burst.

// File: rtl/bcs_pkg.sv
// Package: shared codes for the burst column sequencer.
// Assumes a 3-bit burst length code and a 2-bit organisation code.
package bcs_pkg;

    localparam int BL_CODE_W = 3;
    localparam int ORG_W     = 2;

    typedef enum logic [BL_CODE_W-1:0] {
        BL_1    = 3'd0,
        BL_2    = 3'd1,
        BL_4    = 3'd2,
        BL_8    = 3'd3,
        BL_PAGE = 3'd7
    } bl_code_e;

    typedef enum logic [ORG_W-1:0] {
        ORG_WIDE   = 2'd0,
        ORG_MID    = 2'd1,
        ORG_NARROW = 2'd2
    } org_code_e;

endpackage

// File: rtl/bcs_mode_decode.sv
// Module: bcs_mode_decode
// Turns the length and organisation codes into masks. It produces:
//   org_mask_o - the column bits used by the organisation
//   blk_mask_o - the low bits that move within a burst
//   last_idx_o - the beat index of the final beat (fixed bursts)
//   full_page_o - the burst runs over the whole row
// Assumes COL_W >= 5, so that the two narrowings still leave the 8-beat block.
module bcs_mode_decode #(
    parameter int COL_W = 10
) (
    input  logic [bcs_pkg::BL_CODE_W-1:0] bl_code_i,
    input  logic [bcs_pkg::ORG_W-1:0]     org_i,
    output logic [COL_W-1:0]              org_mask_o,
    output logic [COL_W-1:0]              blk_mask_o,
    output logic [COL_W-1:0]              last_idx_o,
    output logic                          full_page_o
);
    import bcs_pkg::*;

    localparam logic [COL_W-1:0] ALL_ONES = '1;
    localparam logic [COL_W-1:0] MASK_BL2 = COL_W'(1);
    localparam logic [COL_W-1:0] MASK_BL4 = COL_W'(3);
    localparam logic [COL_W-1:0] MASK_BL8 = COL_W'(7);

    // Column bits the selected organisation keeps.
    always_comb begin
        case (org_i)
            ORG_WIDE: org_mask_o = ALL_ONES;
            ORG_MID:  org_mask_o = ALL_ONES >> 1;
            default:  org_mask_o = ALL_ONES >> 2;
        endcase
    end

    // Moving bits and final beat index per length code; reserved codes give one beat.
    always_comb begin
        full_page_o = 1'b0;
        case (bl_code_i)
            BL_2:    blk_mask_o = MASK_BL2;
            BL_4:    blk_mask_o = MASK_BL4;
            BL_8:    blk_mask_o = MASK_BL8;
            BL_PAGE: begin
                blk_mask_o  = org_mask_o;
                full_page_o = 1'b1;
            end
            default: blk_mask_o = '0;
        endcase
        last_idx_o = full_page_o ? '0 : blk_mask_o;
    end

endmodule

// File: rtl/bcs_beat_ctrl.sv
// Module: bcs_beat_ctrl
// Tracks the burst state: valid flag, beat index, last flag.
// A start wins over continuation and over stop. A fixed burst ends after
// its last beat. A full-page burst ends only on stop.
module bcs_beat_ctrl #(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [COL_W-1:0] last_idx_i,
    input  logic             full_page_i,
    output logic             vld_o,
    output logic             last_o,
    output logic             load_o,
    output logic             step_o,
    output logic [COL_W-1:0] idx_next_o
);
    localparam logic [COL_W-1:0] ONE = COL_W'(1);

    logic [COL_W-1:0] idx_q;
    logic [COL_W-1:0] last_idx_q;
    logic             fp_q;
    logic [COL_W-1:0] idx_inc;

    // Next-beat decisions from the current state.
    always_comb begin
        idx_inc    = idx_q + ONE;
        load_o     = start_i;
        step_o     = !start_i && vld_o && !last_o && !stop_i;
        idx_next_o = load_o ? '0 : idx_inc;
    end

    // Burst state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o      <= 1'b0;
            last_o     <= 1'b0;
            idx_q      <= '0;
            last_idx_q <= '0;
            fp_q       <= 1'b0;
        end else if (load_o) begin
            vld_o      <= 1'b1;
            idx_q      <= '0;
            last_idx_q <= last_idx_i;
            fp_q       <= full_page_i;
            last_o     <= !full_page_i && (last_idx_i == '0);
        end else if (step_o) begin
            idx_q  <= idx_inc;
            last_o <= !fp_q && (idx_inc == last_idx_q);
        end else begin
            vld_o  <= 1'b0;
            last_o <= 1'b0;
        end
    end

endmodule

// File: rtl/bcs_addr_gen.sv
// Module: bcs_addr_gen
// Combinational column for beat idx_i of a burst starting at base_i.
// Bits outside blk_mask_i are kept; the bits inside it either add the
// index or XOR it. A full-page burst always adds. The result is clipped
// to the organisation mask. Assumes base_i is already clipped.
module bcs_addr_gen #(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] idx_i,
    input  logic [COL_W-1:0] blk_mask_i,
    input  logic [COL_W-1:0] org_mask_i,
    input  logic             interleave_i,
    input  logic             full_page_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] sum;
    logic [COL_W-1:0] xr;
    logic [COL_W-1:0] low;

    // Pick the moving part and merge it with the fixed upper bits.
    always_comb begin
        sum   = base_i + idx_i;
        xr    = base_i ^ idx_i;
        low   = (interleave_i && !full_page_i) ? xr : sum;
        col_o = ((base_i & ~blk_mask_i) | (low & blk_mask_i)) & org_mask_i;
    end

endmodule

// File: rtl/burst_col_seq.sv
// Module: burst_col_seq (top)
// Emits one column address per clock for an SDRAM burst. Mode inputs are
// captured with start_i, and the outputs are registered: beat 0 appears the
// cycle after the start edge. Assumes a synchronous active-low reset.
module burst_col_seq #(
    parameter int COL_W = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic [COL_W-1:0]              start_col_i,
    input  logic [bcs_pkg::BL_CODE_W-1:0] bl_code_i,
    input  logic                          interleave_i,
    input  logic [bcs_pkg::ORG_W-1:0]     org_i,
    input  logic                          stop_i,
    output logic [COL_W-1:0]              col_o,
    output logic                          beat_vld_o,
    output logic                          last_o
);
    logic [COL_W-1:0] org_mask_live, blk_mask_live, last_idx_live;
    logic             fp_live;
    logic [COL_W-1:0] base_q, blk_q, orgm_q;
    logic             ilv_q, fp_q;
    logic             load, step;
    logic [COL_W-1:0] idx_next;
    logic [COL_W-1:0] base_sel, blk_sel, orgm_sel, col_next;
    logic             ilv_sel, fp_sel;

    bcs_mode_decode #(.COL_W(COL_W)) dec_i (
        .bl_code_i   (bl_code_i),
        .org_i       (org_i),
        .org_mask_o  (org_mask_live),
        .blk_mask_o  (blk_mask_live),
        .last_idx_o  (last_idx_live),
        .full_page_o (fp_live)
    );

    bcs_beat_ctrl #(.COL_W(COL_W)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .stop_i      (stop_i),
        .last_idx_i  (last_idx_live),
        .full_page_i (fp_live),
        .vld_o       (beat_vld_o),
        .last_o      (last_o),
        .load_o      (load),
        .step_o      (step),
        .idx_next_o  (idx_next)
    );

    // Use the live mode on a start, otherwise the captured one.
    always_comb begin
        base_sel = load ? (start_col_i & org_mask_live) : base_q;
        blk_sel  = load ? blk_mask_live : blk_q;
        orgm_sel = load ? org_mask_live : orgm_q;
        ilv_sel  = load ? interleave_i  : ilv_q;
        fp_sel   = load ? fp_live       : fp_q;
    end

    bcs_addr_gen #(.COL_W(COL_W)) addr_i (
        .base_i       (base_sel),
        .idx_i        (idx_next),
        .blk_mask_i   (blk_sel),
        .org_mask_i   (orgm_sel),
        .interleave_i (ilv_sel),
        .full_page_i  (fp_sel),
        .col_o        (col_next)
    );

    // Capture the burst's mode on a start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            blk_q  <= '0;
            orgm_q <= '0;
            ilv_q  <= 1'b0;
            fp_q   <= 1'b0;
        end else if (load) begin
            base_q <= base_sel;
            blk_q  <= blk_sel;
            orgm_q <= orgm_sel;
            ilv_q  <= ilv_sel;
            fp_q   <= fp_sel;
        end
    end

    // Column output register; holds its value between bursts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_o <= '0;
        end else if (load || step) begin
            col_o <= col_next;
        end
    end

endmodule

// File: rtl/bcs_checker.sv
// Module: bcs_checker
// Property checks on the sequencer's ports. It keeps its own copy of the
// organisation mask and the full-page flag, captured on each start.
module bcs_checker #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [2:0]       bl_code_i,
    input logic [1:0]       org_i,
    input logic             stop_i,
    input logic [COL_W-1:0] col_o,
    input logic             beat_vld_o,
    input logic             last_o
);
    localparam logic [COL_W-1:0] ONES = '1;
    localparam logic [COL_W-1:0] ONE  = COL_W'(1);

    logic [COL_W-1:0] omask_q;
    logic             fp_q;

    // Capture the mode each start sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            omask_q <= ONES;
            fp_q    <= 1'b0;
        end else if (start_i) begin
            omask_q <= (org_i == 2'd0) ? ONES : (org_i == 2'd1) ? (ONES >> 1) : (ONES >> 2);
            fp_q    <= (bl_code_i == 3'd7);
        end
    end

    // R2
    start_gives_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> beat_vld_o);

    // R5
    last_only_when_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> beat_vld_o);

    // R5
    idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !beat_vld_o);

    // R6
    single_beat_is_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (bl_code_i == 3'd0)) |=> last_o);

    // R7
    page_never_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld_o && fp_q) |-> !last_o);

    // R7
    page_increments_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld_o && fp_q && !start_i && !stop_i) |=> (col_o == (($past(col_o) + ONE) & omask_q)));

    // R8
    stop_ends_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> !beat_vld_o);

    // R10
    unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_vld_o |-> ((col_o & ~omask_q) == '0));

endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .bl_code_i  (bl_code_i),
    .org_i      (org_i),
    .stop_i     (stop_i),
    .col_o      (col_o),
    .beat_vld_o (beat_vld_o),
    .last_o     (last_o)
);

// File: tb/burst_col_seq_tb_top.sv
// Bench for burst_col_seq. A table of bursts is walked by one loop, then
// directed tests run. Inputs are driven and outputs sampled on the falling edge.
module burst_col_seq_tb_top;

    localparam int COL_W = 10;

    typedef struct packed {
        logic [1:0] org;
        logic [2:0] bl;
        logic       ilv;
        logic [9:0] col;
        logic [7:0] nb;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 3'd3, 1'b0, 10'h2D5, 8'd8},
        '{2'd0, 3'd3, 1'b1, 10'h2D5, 8'd8},
        '{2'd0, 3'd2, 1'b0, 10'h007, 8'd4},
        '{2'd0, 3'd2, 1'b1, 10'h3FE, 8'd4},
        '{2'd1, 3'd1, 1'b0, 10'h3FF, 8'd2},
        '{2'd2, 3'd3, 1'b1, 10'h3A3, 8'd8},
        '{2'd0, 3'd0, 1'b0, 10'h155, 8'd1},
        '{2'd0, 3'd5, 1'b0, 10'h0AA, 8'd1},
        '{2'd2, 3'd7, 1'b0, 10'h0FE, 8'd5},
        '{2'd0, 3'd7, 1'b1, 10'h3FD, 8'd4},
        '{2'd1, 3'd7, 1'b0, 10'h1FF, 8'd3},
        '{2'd3, 3'd1, 1'b1, 10'h301, 8'd2}
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             start_i;
    logic [COL_W-1:0] start_col_i;
    logic [2:0]       bl_code_i;
    logic             interleave_i;
    logic [1:0]       org_i;
    logic             stop_i;
    logic [COL_W-1:0] col_o;
    logic             beat_vld_o;
    logic             last_o;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .start_col_i  (start_col_i),
        .bl_code_i    (bl_code_i),
        .interleave_i (interleave_i),
        .org_i        (org_i),
        .stop_i       (stop_i),
        .col_o        (col_o),
        .beat_vld_o   (beat_vld_o),
        .last_o       (last_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] org_mask(input logic [1:0] org);
        return (org == 2'd0) ? 10'h3FF : (org == 2'd1) ? 10'h1FF : 10'h0FF;
    endfunction

    // Expected column of beat n, taken from R3, R4, R7 and R10.
    function automatic logic [9:0] model_col(input logic [1:0] org, input logic [2:0] bl,
                                             input logic ilv, input logic [9:0] col, input int n);
        logic [9:0] om, s, m, nn;
        om = org_mask(org);
        s  = col & om;
        nn = 10'(n);
        if (bl == 3'd7) return (s + nn) & om;
        m = (bl <= 3'd3) ? (10'(1) << bl) - 10'd1 : 10'd0;
        if (ilv) return (s & ~m) | ((s ^ nn) & m);
        return (s & ~m) | ((s + nn) & m);
    endfunction

    task automatic run_burst(input logic [1:0] org, input logic [2:0] bl, input logic ilv,
                             input logic [9:0] col, input int nb);
        bit fp;
        logic [9:0] om, exp;
        string rq;
        bit exp_last;
        fp = (bl == 3'd7);
        om = org_mask(org);
        @(negedge clk);
        start_i = 1'b1; start_col_i = col; bl_code_i = bl; interleave_i = ilv; org_i = org;
        for (int b = 0; b < nb; b++) begin
            @(negedge clk);
            if (b == 0) begin
                // R11: scramble the mode inputs while the burst runs
                start_i = 1'b0; start_col_i = ~col;
                bl_code_i = fp ? 3'd0 : 3'd7; interleave_i = ~ilv; org_i = org ^ 2'b01;
            end
            exp = model_col(org, bl, ilv, col, b);
            rq = (b == 0) ? "R2" : fp ? "R7" : ilv ? "R4" : "R3";
            chk(beat_vld_o == 1'b1, rq, int'(beat_vld_o), 1);
            chk(col_o == exp, rq, int'(col_o), int'(exp));
            chk((col_o & ~om) == '0, "R10", int'(col_o), int'(col_o & om));
            exp_last = !fp && (b == nb - 1);
            chk(last_o == exp_last, fp ? "R7" : (nb == 1) ? "R6" : "R5", int'(last_o), int'(exp_last));
            if (fp && b == nb - 1) stop_i = 1'b1;
        end
        @(negedge clk);
        chk(beat_vld_o == 1'b0, fp ? "R8" : "R5", int'(beat_vld_o), 0);
        stop_i = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0; start_col_i = '0; bl_code_i = '0;
        interleave_i = 1'b0; org_i = '0; stop_i = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(beat_vld_o == 1'b0 && last_o == 1'b0 && col_o == '0, "R1", int'(col_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(beat_vld_o == 1'b0 && last_o == 1'b0 && col_o == '0, "R1", int'(col_o), 0);

        for (int v = 0; v < NVEC; v++)
            run_burst(VECS[v].org, VECS[v].bl, VECS[v].ilv, VECS[v].col, int'(VECS[v].nb));

        // R9: restart in the middle of an 8-beat burst
        @(negedge clk);
        start_i = 1'b1; start_col_i = 10'h010; bl_code_i = 3'd3; interleave_i = 1'b0; org_i = 2'd0;
        @(negedge clk); start_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(col_o == 10'h012, "R3", int'(col_o), 'h12);
        start_i = 1'b1; start_col_i = 10'h123; bl_code_i = 3'd2; interleave_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk(beat_vld_o && col_o == 10'h123 && !last_o, "R9", int'(col_o), 'h123);
        @(negedge clk);
        chk(col_o == 10'h122, "R9", int'(col_o), 'h122);
        @(negedge clk);
        chk(col_o == 10'h121, "R9", int'(col_o), 'h121);
        @(negedge clk);
        chk(col_o == 10'h120 && last_o, "R9", int'(col_o), 'h120);
        @(negedge clk);
        chk(!beat_vld_o, "R5", int'(beat_vld_o), 0);

        // R9: start and stop on the same edge, start wins
        start_i = 1'b1; stop_i = 1'b1; start_col_i = 10'h040; bl_code_i = 3'd1; interleave_i = 1'b0;
        @(negedge clk); start_i = 1'b0; stop_i = 1'b0;
        chk(beat_vld_o && col_o == 10'h040, "R9", int'(col_o), 'h40);
        @(negedge clk);
        chk(beat_vld_o && col_o == 10'h041 && last_o, "R9", int'(col_o), 'h41);

        // R8: terminate a fixed-length burst early
        @(negedge clk);
        start_i = 1'b1; start_col_i = 10'h100; bl_code_i = 3'd3;
        @(negedge clk); start_i = 1'b0;
        @(negedge clk);
        chk(beat_vld_o && col_o == 10'h101, "R8", int'(col_o), 'h101);
        stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
        chk(!beat_vld_o && !last_o, "R8", int'(beat_vld_o), 0);

        // R11: switching to full page and interleave mid-burst has no effect
        start_i = 1'b1; start_col_i = 10'h006; bl_code_i = 3'd1; interleave_i = 1'b0; org_i = 2'd0;
        @(negedge clk); start_i = 1'b0; bl_code_i = 3'd7; interleave_i = 1'b1; org_i = 2'd2;
        chk(col_o == 10'h006, "R11", int'(col_o), 'h6);
        @(negedge clk);
        chk(col_o == 10'h007 && last_o, "R11", int'(col_o), 'h7);
        @(negedge clk);
        chk(!beat_vld_o, "R11", int'(beat_vld_o), 0);

        // R1: reset in the middle of a full-page burst
        start_i = 1'b1; start_col_i = 10'h020; bl_code_i = 3'd7;
        @(negedge clk); start_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!beat_vld_o && !last_o && col_o == '0, "R1", int'(col_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!beat_vld_o && col_o == '0, "R1", int'(beat_vld_o), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule